// File: doc/BRIEF.md
# Packed SIMD Saturating Adder

This block treats two 32-bit operands as one word, two halfword lanes or four byte lanes, and adds or subtracts them lane by lane in a single pass. Carries never cross a lane boundary. Each lane wraps modulo its width, clamps to its signed bounds, or clamps to its unsigned bounds, depending on the selected mode. Two more operations are available. The first swaps the two halfwords of the second operand before the add or subtract. The second returns the unsigned sum of the four byte-lane absolute differences.

A caller presents the operands together with lane, operation and mode selects, and raises `inValid`. One clock later the packed result appears with `outValid`, along with one flag per lane that shows which lanes were clamped. The result stays unchanged until the next accepted request.

Top module: `simd_sat_alu`

## Requirements
- R1: During and after reset, `outValid` is 0 and `result` and `satFlags` are all zero until the first request is accepted.
- R2: A request with `inValid` high at a rising edge is captured there. `outValid` is high for exactly the following cycle, and `result` and `satFlags` show the answer in that same cycle.
- R3: When `inValid` is low at an edge, `result` and `satFlags` keep their previous values and `outValid` is low in the next cycle.
- R4: Mode 0 (wrap) adds or subtracts each lane modulo 2^width, with no carry or borrow between lanes. For example, byte 0x7D + 0x04 gives 0x81, and 0x00FF00FF + 0x00010001 in byte lanes gives 0x00000000.
- R5: Mode 1 (signed saturation) clamps each lane to its two's-complement range: -128..127 for bytes, -32768..32767 for halfwords, and -2^31..2^31-1 for the word.
- R6: Mode 2 (unsigned saturation) clamps each lane to 0..2^width-1, so an overflowing add gives all ones and a borrowing subtract gives zero.
- R7: `satFlags` bit i is 1 exactly when lane i was clamped. Lane i occupies bits [8i+7:8i] for bytes, [16i+15:16i] for halfwords, and the whole word for the single lane 0. Flag bits at or above the lane count are 0, and every flag is 0 in wrap mode.
- R8: Lane select encodes 0 as word, 1 as halfwords, 2 as bytes, and 3 also as word.
- R9: Operation select encodes 0 as add and 1 as subtract (a minus b). Code 2 adds and code 3 subtracts after the upper and lower 16-bit halves of b have been exchanged. Codes 5 to 7 behave as add. Mode code 3 behaves as wrap.
- R10: Operation code 4 returns the 32-bit unsigned sum of |a_byte - b_byte| over the four unsigned byte lanes. It ignores the lane and mode selects and clears all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| laneSel | input | 2 | Lane size select |
| opSel | input | 3 | Operation select |
| modeSel | input | 2 | Overflow mode select |
| outValid | output | 1 | Result strobe, one cycle after request |
| result | output | 32 | Registered packed result |
| satFlags | output | 4 | Per-lane clamp indicators |

## Verification
The bench targets lane boundaries. A carry leaking from one lane into the next would corrupt 0x00FF00FF + 0x00010001, and a signed clamp applied with the wrong bounds would turn 125 + 4 into 255 or 0 instead of 127. Subtractions that borrow are run under unsigned saturation, where a design that confuses borrow with overflow would return all ones rather than zero. Other stimuli check the halfword exchange, the reserved codes, and the absolute-difference sum with mixed byte orderings. They catch a design that swaps the wrong operand, flags a sum lane, or lets `result` drift during idle cycles.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int DATA_W = 32;
  localparam int NUM_BYTE = DATA_W / 8;
  localparam int NUM_HALF = DATA_W / 16;

  typedef enum logic [1:0] {LANE_WORD = 2'd0, LANE_HALF = 2'd1, LANE_BYTE = 2'd2, LANE_ALT = 2'd3} laneSel_e;
  typedef enum logic [1:0] {MODE_WRAP = 2'd0, MODE_SSAT = 2'd1, MODE_USAT = 2'd2, MODE_ALT = 2'd3} modeSel_e;
  typedef enum logic [2:0] {OP_ADD = 3'd0, OP_SUB = 3'd1, OP_XADD = 3'd2, OP_XSUB = 3'd3, OP_SAD = 3'd4} opSel_e;

  typedef enum logic [1:0] {W_WORD = 2'd0, W_HALF = 2'd1, W_BYTE = 2'd2} width_e;

  typedef struct packed {
    logic   capture;
    logic   isSub;
    logic   swapB;
    logic   doSad;
    logic   satOn;
    logic   satSigned;
    width_e width;
  } dpCtrl_t;
endpackage

// File: rtl/simd_lane.sv
module simd_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         isSub,
  input  logic         satOn,
  input  logic         satSigned,
  output logic [W-1:0] y,
  output logic         clamped
);
  localparam int EXT_W = W + 2;

  logic [EXT_W-1:0] extA, extB, raw;
  logic sOver, uOver, uUnder;

  always_comb begin
    extA = satSigned ? {{2{a[W-1]}}, a} : {2'b00, a};
    extB = satSigned ? {{2{b[W-1]}}, b} : {2'b00, b};
    raw  = isSub ? (extA - extB) : (extA + extB);
    sOver  = !((raw[W+1] == raw[W]) && (raw[W] == raw[W-1]));
    uUnder = raw[W+1];
    uOver  = raw[W] & ~raw[W+1];
    y = raw[W-1:0];
    clamped = 1'b0;
    if (satOn && satSigned && sOver) begin
      clamped = 1'b1;
      y = raw[W+1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    end else if (satOn && !satSigned && (uUnder || uOver)) begin
      clamped = 1'b1;
      y = uUnder ? {W{1'b0}} : {W{1'b1}};
    end
  end
endmodule

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic [1:0] laneSel,
  input  logic [2:0] opSel,
  input  logic [1:0] modeSel,
  output dpCtrl_t strobes,
  output logic    outValid
);
  laneSel_e laneE;
  modeSel_e modeE;
  opSel_e   opE;

  always_comb begin
    laneE = laneSel_e'(laneSel);
    modeE = modeSel_e'(modeSel);
    opE   = opSel_e'(opSel);
    strobes.capture   = inValid;
    strobes.doSad     = (opE == OP_SAD);
    strobes.isSub     = (opE == OP_SUB) || (opE == OP_XSUB);
    strobes.swapB     = (opE == OP_XADD) || (opE == OP_XSUB);
    strobes.satOn     = (modeE == MODE_SSAT) || (modeE == MODE_USAT);
    strobes.satSigned = (modeE == MODE_SSAT);
    case (laneE)
      LANE_HALF: strobes.width = W_HALF;
      LANE_BYTE: strobes.width = W_BYTE;
      default:   strobes.width = W_WORD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2: a captured request yields a strobe in the following cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R3: an idle edge produces no output strobe
  a_r3_idle_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/simd_dp.sv
module simd_dp
  import simd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic [NUM_BYTE-1:0] satFlags
);
  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = 8;
  localparam int HALF_SPAN = 16;

  logic [DATA_W-1:0] bIn;
  logic [DATA_W-1:0] byteY, halfY, wordY, sadY, nextY;
  logic [NUM_BYTE-1:0] byteC, nextF;
  logic [NUM_HALF-1:0] halfC;
  logic wordC;

  assign bIn = strobes.swapB ? {opB[HALF_W-1:0], opB[DATA_W-1:HALF_W]} : opB;

  for (genvar g = 0; g < NUM_BYTE; g++) begin : gByte
    simd_lane #(.W(BYTE_W)) uLane (
      .a(opA[g*BYTE_W +: BYTE_W]), .b(bIn[g*BYTE_W +: BYTE_W]),
      .isSub(strobes.isSub), .satOn(strobes.satOn), .satSigned(strobes.satSigned),
      .y(byteY[g*BYTE_W +: BYTE_W]), .clamped(byteC[g]));
  end

  for (genvar g = 0; g < NUM_HALF; g++) begin : gHalf
    simd_lane #(.W(HALF_SPAN)) uLane (
      .a(opA[g*HALF_SPAN +: HALF_SPAN]), .b(bIn[g*HALF_SPAN +: HALF_SPAN]),
      .isSub(strobes.isSub), .satOn(strobes.satOn), .satSigned(strobes.satSigned),
      .y(halfY[g*HALF_SPAN +: HALF_SPAN]), .clamped(halfC[g]));
  end

  simd_lane #(.W(DATA_W)) uWord (
    .a(opA), .b(bIn),
    .isSub(strobes.isSub), .satOn(strobes.satOn), .satSigned(strobes.satSigned),
    .y(wordY), .clamped(wordC));

  always_comb begin
    sadY = '0;
    for (int i = 0; i < NUM_BYTE; i++) begin
      if (opA[i*BYTE_W +: BYTE_W] >= opB[i*BYTE_W +: BYTE_W])
        sadY = sadY + DATA_W'(opA[i*BYTE_W +: BYTE_W] - opB[i*BYTE_W +: BYTE_W]);
      else
        sadY = sadY + DATA_W'(opB[i*BYTE_W +: BYTE_W] - opA[i*BYTE_W +: BYTE_W]);
    end
  end

  always_comb begin
    nextF = '0;
    if (strobes.doSad) begin
      nextY = sadY;
    end else begin
      case (strobes.width)
        W_BYTE: begin nextY = byteY; nextF = byteC; end
        W_HALF: begin nextY = halfY; nextF[NUM_HALF-1:0] = halfC; end
        default: begin nextY = wordY; nextF[0] = wordC; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      satFlags <= '0;
    end else if (strobes.capture) begin
      result   <= nextY;
      satFlags <= nextF;
    end
  end

  // R3: no capture, no change
  a_r3_hold_result: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(result) && $stable(satFlags)));
  // R7: wrap mode never raises a flag
  a_r7_wrap_no_flag: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !strobes.satOn) |=> (satFlags == '0));
  // R7: halfword lanes leave the upper flags clear
  a_r7_half_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !strobes.doSad && strobes.width == W_HALF) |=> (satFlags[NUM_BYTE-1:NUM_HALF] == '0));
  // R10: sum of absolute differences clears every flag
  a_r10_sad_no_flag: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && strobes.doSad) |=> (satFlags == '0));
endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
  import simd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [1:0]  laneSel,
  input  logic [2:0]  opSel,
  input  logic [1:0]  modeSel,
  output logic        outValid,
  output logic [31:0] result,
  output logic [3:0]  satFlags
);
  dpCtrl_t strobes;

  simd_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .laneSel(laneSel), .opSel(opSel), .modeSel(modeSel),
    .strobes(strobes), .outValid(outValid));

  simd_dp uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .opA(opA), .opB(opB), .result(result), .satFlags(satFlags));
endmodule

// File: tb/simd_sat_alu_tb.sv
module simd_sat_alu_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [1:0] laneSel = '0, modeSel = '0;
  logic [2:0] opSel = '0;
  logic outValid;
  logic [31:0] result;
  logic [3:0] satFlags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] r;
    logic [3:0]  f;
    string       tag;
  } exp_t;
  exp_t expQ[$];
  logic [31:0] lastR = '0;
  logic [3:0]  lastF = '0;

  always #10 clk = ~clk;

  simd_sat_alu dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .laneSel(laneSel), .opSel(opSel), .modeSel(modeSel),
    .outValid(outValid), .result(result), .satFlags(satFlags));

  function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                input logic [1:0] ls, input logic [2:0] op,
                                input logic [1:0] md,
                                output logic [31:0] r, output logic [3:0] f);
    longint w, n, ua, ub, sa, sb, v, lo, hi, mask, sum;
    logic [31:0] bb;
    r = '0; f = '0;
    if (op == 3'd4) begin
      sum = 0;
      for (int i = 0; i < 4; i++) begin
        ua = longint'(a[i*8 +: 8]); ub = longint'(b[i*8 +: 8]);
        sum += (ua > ub) ? ua - ub : ub - ua;
      end
      r = 32'(sum);
      return;
    end
    bb = (op == 3'd2 || op == 3'd3) ? {b[15:0], b[31:16]} : b;
    w = (ls == 2'd1) ? 16 : (ls == 2'd2) ? 8 : 32;
    n = 32 / w;
    mask = (longint'(1) << w) - 1;
    for (int i = 0; i < n; i++) begin
      ua = (longint'(a) >> (i * w)) & mask;
      ub = (longint'(bb) >> (i * w)) & mask;
      sa = (ua >= (longint'(1) << (w - 1))) ? ua - (longint'(1) << w) : ua;
      sb = (ub >= (longint'(1) << (w - 1))) ? ub - (longint'(1) << w) : ub;
      if (md == 2'd1) begin
        v = (op == 3'd1 || op == 3'd3) ? sa - sb : sa + sb;
        lo = -(longint'(1) << (w - 1)); hi = (longint'(1) << (w - 1)) - 1;
        if (v < lo) begin v = lo; f[i] = 1'b1; end
        if (v > hi) begin v = hi; f[i] = 1'b1; end
      end else begin
        v = (op == 3'd1 || op == 3'd3) ? ua - ub : ua + ub;
        if (md == 2'd2) begin
          if (v < 0) begin v = 0; f[i] = 1'b1; end
          if (v > mask) begin v = mask; f[i] = 1'b1; end
        end
      end
      r = r | 32'((v & mask) << (i * w));
    end
  endfunction

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [1:0] ls,
                       input logic [2:0] op, input logic [1:0] md, input string tag);
    exp_t e;
    model(a, b, ls, op, md, e.r, e.f);
    e.tag = tag;
    expQ.push_back(e);
    opA = a; opB = b; laneSel = ls; opSel = op; modeSel = md; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: compares at the falling edge, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (outValid) begin
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R2: outValid without request, result=%h expected no strobe", result);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          if (result !== e.r || satFlags !== e.f) begin
            errors++;
            $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                     e.tag, result, satFlags, e.r, e.f);
          end
          lastR = e.r; lastF = e.f;
        end
      end else if (result !== lastR || satFlags !== lastF) begin
        errors++;
        $display("FAIL R3/R1: idle result=%h flags=%b expected result=%h flags=%b",
                 result, satFlags, lastR, lastF);
      end
    end
  end

  initial begin
    #100000000;
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] ra, rb;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (outValid !== 1'b0 || result !== '0 || satFlags !== '0) begin
      errors++;
      $display("FAIL R1: valid=%b result=%h flags=%b expected 0/0/0", outValid, result, satFlags);
    end
    rstN = 1'b1;
    idle(2);
    drive(32'h7D7D_7D7D, 32'h0404_0404, 2'd2, 3'd0, 2'd0, "R4 byte wrap 125+4");
    drive(32'h00FF_00FF, 32'h0001_0001, 2'd2, 3'd0, 2'd0, "R4 no inter-lane carry");
    drive(32'h0000_FFFF, 32'h0000_0001, 2'd1, 3'd0, 2'd0, "R4 half wrap");
    idle(3);
    drive(32'h7D7D_7D7D, 32'h0404_7D00, 2'd2, 3'd0, 2'd1, "R5 R7 byte signed clamp");
    drive(32'h8080_7F01, 32'h0101_FF02, 2'd2, 3'd1, 2'd1, "R5 R7 byte signed sub");
    drive(32'h8000_7FFF, 32'h0001_0001, 2'd1, 3'd1, 2'd1, "R5 R7 half signed sub");
    drive(32'h7FFF_FFFF, 32'h0000_0001, 2'd0, 3'd0, 2'd1, "R5 word signed max");
    drive(32'hFF10_0080, 32'h0220_0080, 2'd2, 3'd0, 2'd2, "R6 R7 byte unsigned add");
    drive(32'h0510_0000, 32'h0620_0001, 2'd2, 3'd1, 2'd2, "R6 R7 byte unsigned borrow");
    drive(32'hFFFF_0003, 32'h0001_0005, 2'd1, 3'd0, 2'd2, "R6 half unsigned");
    drive(32'h0000_0000, 32'h0000_0001, 2'd0, 3'd1, 2'd2, "R6 word unsigned borrow");
    idle(2);
    drive(32'h1000_0001, 32'h0002_3000, 2'd1, 3'd2, 2'd0, "R9 exchange add");
    drive(32'h1000_0001, 32'h0002_3000, 2'd1, 3'd3, 2'd2, "R9 exchange sub unsigned");
    drive(32'h0102_0304, 32'h0506_0708, 2'd2, 3'd2, 2'd0, "R9 exchange bytes");
    drive(32'h10F0_0580, 32'hF010_0A80, 2'd1, 3'd4, 2'd1, "R10 sad mixed order");
    drive(32'hFF00_FF00, 32'h00FF_00FF, 2'd0, 3'd4, 2'd2, "R10 sad max");
    drive(32'h7FFF_FFFF, 32'h0000_0001, 2'd3, 3'd0, 2'd1, "R8 lane code 3 as word");
    drive(32'h7D7D_7D7D, 32'h0404_0404, 2'd2, 3'd0, 2'd3, "R9 mode 3 as wrap");
    drive(32'h1234_5678, 32'h1111_1111, 2'd1, 3'd5, 2'd0, "R9 op 5 as add");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 2'd2, 3'd7, 2'd2, "R9 op 7 as add");
    idle(4);
    for (int k = 0; k < 300; k++) begin
      ra = $urandom; rb = $urandom;
      drive(ra, rb, 2'($urandom), 3'($urandom), 2'($urandom), "R2 R7 mixed stream");
      if ((k % 7) == 0) idle(1);
    end
    idle(3);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d results missing, expected 0", expQ.size());
    end
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule